// File: doc/BRIEF.md
# Standby Power Sequencer

This block sequences the deepest software power-down of a small microcontroller. A one-cycle sleep strobe from the CPU puts the chip into standby only when three configuration bits agree. In standby the block gates the oscillator, the CPU clock and the peripheral clocks, and holds the non-retained peripheral group in reset. Register, RAM and port state stay untouched.

The block leaves standby along one of three paths:
- **Interrupt wake.** A wake interrupt restarts the oscillator. The clocks stay gated while a programmable settling count runs on a free-running reference tick. Then the clocks return and a one-cycle interrupt-exception start pulse is issued.
- **Reset-pin wake.** Pulling the reset pin low restores the oscillator and all clocks at once. A reset-exception start pulse follows when the pin is released.
- **Hardware-standby pin.** Pulling this pin low overrides everything. The block drops into a hardware-standby state that only the system reset clears.

The block runs on an always-on controller clock. All pin inputs are assumed to be already synchronous to it.

Top module: `stby_ctrl`

## Requirements
- R1: A sleep strobe enters standby only when the standby-select bit is 1, the low-speed bit is 0 and the watchdog-prescaler bit is 0. Any other combination leaves all clocks running.
- R2: In standby, osc_en_o, cpu_clk_en_o and per_clk_en_o are all 0 from the cycle after the accepted sleep strobe.
- R3: per_rst_o is 1 in standby, settling and hardware standby, and 0 in normal run.
- R4: Only NMI and request lines 0, 1, 2, 6 and 7 can wake from standby. Lines 3, 4 and 5 never wake, even when enabled.
- R5: A request line wakes only when its enable bit is 1 and cpu_mask_i is 0. NMI wakes regardless of cpu_mask_i.
- R6: On an interrupt wake, osc_en_o is 1 while cpu_clk_en_o is 0 for the settling window, which is N+1 cycles when the tick is high every cycle. After the window, all clocks return and irq_exc_start_o is high for exactly that first run cycle.
- R7: The settle select maps codes 0 to 5 to 2^(SETTLE_BASE_LOG2+code) ticks and codes 6 and 7 to SHORT_COUNT ticks. The count advances only on cycles where ref_tick_i is 1.
- R8: A low reset pin in standby or settling turns on osc_en_o, cpu_clk_en_o and per_clk_en_o in the next cycle, with no settling wait.
- R9: When res_ni returns high in the reset-hold state, rst_exc_start_o is high for exactly one cycle, the first run cycle. It stays 0 while the pin is held low.
- R10: A low hardware-standby pin moves the block from any state to hardware standby: hw_stby_o is 1 and all clocks are off. The block stays there, whatever the pins do, until rst_ni is asserted.
- R11: Simultaneous events resolve with the hardware-standby pin first, then the reset pin, then NMI and request lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| sleep_i | input | 1 | One-cycle sleep-instruction strobe |
| cfg_stby_sel_i | input | 1 | Standby-select configuration bit |
| cfg_low_speed_i | input | 1 | Low-speed-on configuration bit |
| cfg_wdt_psel_i | input | 1 | Watchdog prescaler-select bit |
| settle_sel_i | input | 3 | Settling-time code |
| ref_tick_i | input | 1 | Free-running reference tick for settling |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | IRQ_W | Maskable interrupt request lines |
| irq_en_i | input | IRQ_W | Per-line interrupt enables |
| cpu_mask_i | input | 1 | CPU interrupt mask, blocks all maskable lines |
| res_ni | input | 1 | Active-low reset pin |
| hwstby_ni | input | 1 | Active-low hardware-standby pin |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| per_rst_o | output | 1 | Reset to the non-retained peripheral group |
| irq_exc_start_o | output | 1 | Interrupt-exception start pulse |
| rst_exc_start_o | output | 1 | Reset-exception start pulse |
| hw_stby_o | output | 1 | Hardware-standby state indicator |

## Verification
The entry gate is tried with every wrong setting of the three configuration bits, one bit at a time, and then with the single accepted setting. This separates a full three-way qualification from a partial one.

Interrupt wake is driven from a valid line, from NMI with the mask set, from lines outside the wake set, from a disabled line and from a masked line. These separate the fixed wake set, the per-line enable, and the NMI mask exemption.

The settling window is measured for several codes, including the short codes, and once with a tick every other cycle. This separates the code table from tick qualification.

Events are also applied together with the reset pin and the hardware-standby pin, in standby and in settling. These separate the priority order and the immediate-clock reset path from the counted interrupt path.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STANDBY,
    ST_SETTLING,
    ST_HW_STANDBY,
    ST_RESET_HOLD
  } pm_state_e;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_HWSTBY,
    WK_RESET,
    WK_NMI,
    WK_IRQ
  } wake_src_e;
endpackage

// File: rtl/stby_wake_arb.sv
module stby_wake_arb
  import stby_pkg::*;
#(
  parameter int unsigned       IRQ_W      = 8,
  parameter logic [IRQ_W-1:0]  WAKE_LINES = 8'hC7
) (
  input  logic             hwstby_ni,
  input  logic             res_ni,
  input  logic             nmi_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  output wake_src_e        wake_src_o
);
  logic [IRQ_W-1:0] qual;

  for (genvar g = 0; g < IRQ_W; g++) begin : g_line
    if (WAKE_LINES[g]) begin : g_wake
      assign qual[g] = irq_i[g] & irq_en_i[g] & ~cpu_mask_i;
    end else begin : g_dead
      assign qual[g] = 1'b0;
    end
  end

  // fixed priority: hw standby > reset pin > nmi > maskable
  always_comb begin
    if (!hwstby_ni)  wake_src_o = WK_HWSTBY;
    else if (!res_ni) wake_src_o = WK_RESET;
    else if (nmi_i)   wake_src_o = WK_NMI;
    else if (|qual)   wake_src_o = WK_IRQ;
    else              wake_src_o = WK_NONE;
  end
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int unsigned SETTLE_BASE_LOG2 = 13,
  parameter int unsigned SHORT_COUNT      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] sel_i,
  input  logic       tick_i,
  output logic       done_o
);
  localparam int unsigned CNT_W = SETTLE_BASE_LOG2 + 6;
  localparam logic [CNT_W-1:0] MAX_LOAD = CNT_W'(1) << (SETTLE_BASE_LOG2 + 5);

  logic [CNT_W-1:0] cnt_q, load_val;

  always_comb begin
    if (sel_i <= 3'd5) load_val = CNT_W'(1) << (SETTLE_BASE_LOG2 + 32'(sel_i));
    else               load_val = CNT_W'(SHORT_COUNT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_LOAD); // R7
  AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !tick_i |=> cnt_q == $past(cnt_q)); // R7
endmodule

// File: rtl/stby_out_dec.sv
module stby_out_dec
  import stby_pkg::*;
(
  input  pm_state_e state_i,
  output logic      osc_en_o,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      per_rst_o,
  output logic      hw_stby_o
);
  always_comb begin
    osc_en_o     = 1'b0;
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    per_rst_o    = 1'b1;
    hw_stby_o    = 1'b0;
    unique case (state_i)
      ST_RUN, ST_RESET_HOLD: begin
        osc_en_o     = 1'b1;
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        per_rst_o    = 1'b0;
      end
      ST_SETTLING:   osc_en_o  = 1'b1;
      ST_HW_STANDBY: hw_stby_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned      IRQ_W            = 8,
  parameter logic [IRQ_W-1:0] WAKE_LINES       = 8'hC7,
  parameter int unsigned      SETTLE_BASE_LOG2 = 13,
  parameter int unsigned      SHORT_COUNT      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             cfg_stby_sel_i,
  input  logic             cfg_low_speed_i,
  input  logic             cfg_wdt_psel_i,
  input  logic [2:0]       settle_sel_i,
  input  logic             ref_tick_i,
  input  logic             nmi_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  input  logic             res_ni,
  input  logic             hwstby_ni,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             per_rst_o,
  output logic             irq_exc_start_o,
  output logic             rst_exc_start_o,
  output logic             hw_stby_o
);
  pm_state_e state_q, state_d;
  wake_src_e wake_src;
  logic      entry_ok, load, done, irq_go, rst_go;
  logic      irq_pulse_q, rst_pulse_q;

  assign entry_ok = sleep_i & cfg_stby_sel_i & ~cfg_low_speed_i & ~cfg_wdt_psel_i;

  stby_wake_arb #(.IRQ_W(IRQ_W), .WAKE_LINES(WAKE_LINES)) u_arb (
    .hwstby_ni (hwstby_ni),
    .res_ni    (res_ni),
    .nmi_i     (nmi_i),
    .irq_i     (irq_i),
    .irq_en_i  (irq_en_i),
    .cpu_mask_i(cpu_mask_i),
    .wake_src_o(wake_src)
  );

  stby_settle_timer #(
    .SETTLE_BASE_LOG2(SETTLE_BASE_LOG2),
    .SHORT_COUNT     (SHORT_COUNT)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .sel_i (settle_sel_i),
    .tick_i(ref_tick_i),
    .done_o(done)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    irq_go  = 1'b0;
    rst_go  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wake_src == WK_HWSTBY)     state_d = ST_HW_STANDBY;
        else if (wake_src == WK_RESET) state_d = ST_RESET_HOLD;
        else if (entry_ok)             state_d = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (wake_src == WK_HWSTBY)     state_d = ST_HW_STANDBY;
        else if (wake_src == WK_RESET) state_d = ST_RESET_HOLD;
        else if (wake_src == WK_NMI || wake_src == WK_IRQ) begin
          state_d = ST_SETTLING;
          load    = 1'b1;
        end
      end
      ST_SETTLING: begin
        if (wake_src == WK_HWSTBY)     state_d = ST_HW_STANDBY;
        else if (wake_src == WK_RESET) state_d = ST_RESET_HOLD;
        else if (done) begin
          state_d = ST_RUN;
          irq_go  = 1'b1;
        end
      end
      ST_RESET_HOLD: begin
        if (wake_src == WK_HWSTBY)     state_d = ST_HW_STANDBY;
        else if (wake_src != WK_RESET) begin
          state_d = ST_RUN;
          rst_go  = 1'b1;
        end
      end
      ST_HW_STANDBY: state_d = ST_HW_STANDBY;
      default:       state_d = ST_HW_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      irq_pulse_q <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      irq_pulse_q <= irq_go;
      rst_pulse_q <= rst_go;
    end
  end

  assign irq_exc_start_o = irq_pulse_q;
  assign rst_exc_start_o = rst_pulse_q;

  stby_out_dec u_dec (
    .state_i     (state_q),
    .osc_en_o    (osc_en_o),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .per_rst_o   (per_rst_o),
    .hw_stby_o   (hw_stby_o)
  );

  AST_ENTRY_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STANDBY && $past(state_q) == ST_RUN
      |-> $past(sleep_i && cfg_stby_sel_i && !cfg_low_speed_i && !cfg_wdt_psel_i)); // R1
  AST_STBY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STANDBY |-> !osc_en_o && !cpu_clk_en_o && !per_clk_en_o); // R2
  AST_CLK_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_en_o); // R6
  AST_IRQ_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_start_o |-> $past(state_q) == ST_SETTLING && cpu_clk_en_o); // R6
  AST_IRQ_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_start_o |=> !irq_exc_start_o); // R6
  AST_RESET_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STANDBY || state_q == ST_SETTLING) && !res_ni && hwstby_ni
      |=> osc_en_o && cpu_clk_en_o); // R8
  AST_RST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_exc_start_o |-> $past(state_q) == ST_RESET_HOLD && $past(res_ni)); // R9
  AST_HW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_o |=> hw_stby_o && !osc_en_o); // R10
  AST_HW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hwstby_ni |=> hw_stby_o); // R11
endmodule

// File: tb/stby_ctrl_test.sv
`timescale 1ns/1ps
module stby_ctrl_test;
  localparam int BASE  = 3;
  localparam int SHORT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 0, sel = 1, lspd = 0, psel = 0, tick = 1, nmi = 0, mask = 0;
  logic res_n = 1, hws_n = 1;
  logic [2:0] code = 0;
  logic [7:0] irq = 0, irq_en = 0;
  logic osc, cpu, per, prst, iexc, rexc, hws;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  stby_ctrl #(.SETTLE_BASE_LOG2(BASE), .SHORT_COUNT(SHORT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .cfg_stby_sel_i(sel),
    .cfg_low_speed_i(lspd), .cfg_wdt_psel_i(psel), .settle_sel_i(code),
    .ref_tick_i(tick), .nmi_i(nmi), .irq_i(irq), .irq_en_i(irq_en),
    .cpu_mask_i(mask), .res_ni(res_n), .hwstby_ni(hws_n),
    .osc_en_o(osc), .cpu_clk_en_o(cpu), .per_clk_en_o(per), .per_rst_o(prst),
    .irq_exc_start_o(iexc), .rst_exc_start_o(rexc), .hw_stby_o(hws));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sleep_pulse(logic s, logic l, logic p);
    @(negedge clk); sel = s; lspd = l; psel = p; sleep = 1;
    step();
    @(negedge clk); sleep = 0; sel = 1; lspd = 0; psel = 0;
  endtask

  function automatic int settle_n(logic [2:0] c);
    return (c <= 5) ? (1 << (BASE + c)) : SHORT;
  endfunction

  task automatic measure_settle(output int n);
    n = 0;
    while (!cpu && n < 5000) begin n++; step(); end
  endtask

  task automatic t_reset_state();
    chk("R3", "run osc/cpu/per", {osc, cpu, per}, 3'b111);
    chk("R3", "run per_rst", prst, 0);
    chk("R10", "run hw_stby", hws, 0);
    chk("R6", "no pulses", {iexc, rexc}, 0);
  endtask

  task automatic t_entry();
    sleep_pulse(0, 0, 0); chk("R1", "stby_sel=0 keeps clocks", {osc, cpu}, 2'b11);
    sleep_pulse(1, 1, 0); chk("R1", "low_speed=1 keeps clocks", {osc, cpu}, 2'b11);
    sleep_pulse(1, 0, 1); chk("R1", "wdt_psel=1 keeps clocks", {osc, cpu}, 2'b11);
    sleep_pulse(1, 0, 0);
    chk("R2", "standby clocks off", {osc, cpu, per}, 3'b000);
    chk("R3", "standby per_rst", prst, 1);
  endtask

  task automatic t_irq_wake(int line, logic [2:0] c);
    int n;
    code = c;
    @(negedge clk); irq[line] = 1; irq_en[line] = 1;
    step();
    chk("R6", "settling osc on cpu off", {osc, cpu}, 2'b10);
    chk("R3", "settling per_rst", prst, 1);
    measure_settle(n);
    chk("R7", $sformatf("window code %0d", c), n, settle_n(c) + 1);
    chk("R6", "irq start pulse", iexc, 1);
    chk("R6", "clocks back", {osc, cpu, per, prst}, 4'b1110);
    @(negedge clk); irq = 0; irq_en = 0;
    step();
    chk("R6", "pulse one cycle", iexc, 0);
  endtask

  task automatic t_no_wake();
    sleep_pulse(1, 0, 0);
    @(negedge clk); irq = 8'h38; irq_en = 8'hFF;
    repeat (4) step();
    chk("R4", "lines 3-5 do not wake", osc, 0);
    @(negedge clk); irq = 8'h01; irq_en = 8'h00;
    repeat (3) step();
    chk("R5", "disabled line does not wake", osc, 0);
    @(negedge clk); irq_en = 8'h01; mask = 1;
    repeat (3) step();
    chk("R5", "masked line does not wake", osc, 0);
    @(negedge clk); irq = 0; irq_en = 0; nmi = 1; code = 6;
    step();
    chk("R5", "nmi wakes through mask", {osc, cpu}, 2'b10);
    @(negedge clk); nmi = 0; mask = 0;
    step();
    while (!cpu) step();
    chk("R4", "nmi wake completes", iexc, 1);
  endtask

  task automatic t_sparse_tick();
    int n;
    sleep_pulse(1, 0, 0);
    code = 7;
    @(negedge clk); nmi = 1;
    step();
    @(negedge clk); nmi = 0;
    fork
      begin
        while (!cpu) begin @(negedge clk); tick = ~tick; end
      end
      begin
        n = 1;
        step();
        while (!cpu && n < 5000) begin n++; step(); end
      end
    join
    tick = 1;
    checks++;
    if (n < 2 * SHORT || n > 2 * SHORT + 1) begin
      errors++;
      $display("FAIL R7 sparse tick window: actual %0d expected %0d..%0d", n, 2 * SHORT, 2 * SHORT + 1);
    end
  endtask

  task automatic t_reset_wake();
    sleep_pulse(1, 0, 0);
    @(negedge clk); res_n = 0;
    step();
    chk("R8", "reset pin clocks at once", {osc, cpu, per}, 3'b111);
    repeat (3) step();
    chk("R9", "no start while held", rexc, 0);
    @(negedge clk); res_n = 1;
    step();
    chk("R9", "reset start pulse", rexc, 1);
    step();
    chk("R9", "reset pulse one cycle", rexc, 0);
    // reset during settling
    sleep_pulse(1, 0, 0);
    code = 5;
    @(negedge clk); irq[7] = 1; irq_en[7] = 1;
    repeat (3) step();
    chk("R6", "line 7 settling", {osc, cpu}, 2'b10);
    @(negedge clk); res_n = 0; irq = 0; irq_en = 0;
    step();
    chk("R8", "reset aborts settling", {osc, cpu}, 2'b11);
    chk("R8", "no irq pulse", iexc, 0);
    @(negedge clk); res_n = 1;
    step();
    chk("R9", "pulse after settle abort", rexc, 1);
  endtask

  task automatic t_priority();
    sleep_pulse(1, 0, 0);
    @(negedge clk); nmi = 1; res_n = 0;
    step();
    chk("R11", "reset beats nmi", {osc, cpu}, 2'b11);
    @(negedge clk); nmi = 0; res_n = 1;
    step();
    sleep_pulse(1, 0, 0);
    @(negedge clk); nmi = 1; res_n = 0; hws_n = 0;
    step();
    chk("R11", "hw standby beats all", {hws, osc, cpu}, 3'b100);
    @(negedge clk); nmi = 0; res_n = 1; hws_n = 1;
    repeat (3) step();
    chk("R10", "hw standby sticky", {hws, osc, prst}, 3'b101);
    @(negedge clk); res_n = 0;
    repeat (2) step();
    @(negedge clk); res_n = 1; nmi = 1;
    repeat (2) step();
    chk("R10", "reset pin cannot leave hw", {hws, osc, rexc, iexc}, 4'b1000);
    @(negedge clk); nmi = 0; rst_n = 0;
    step();
    @(negedge clk); rst_n = 1;
    step();
    chk("R10", "system reset clears hw", {hws, osc, cpu}, 3'b011);
    @(negedge clk); hws_n = 0;
    step();
    chk("R10", "hw from run", {hws, osc, cpu, per}, 4'b1000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step();
    t_reset_state();
    t_entry();
    t_irq_wake(0, 3'd0);
    sleep_pulse(1, 0, 0); t_irq_wake(1, 3'd2);
    sleep_pulse(1, 0, 0); t_irq_wake(2, 3'd5);
    sleep_pulse(1, 0, 0); t_irq_wake(6, 3'd6);
    sleep_pulse(1, 0, 0); t_irq_wake(7, 3'd7);
    t_no_wake();
    t_sparse_tick();
    t_reset_wake();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule